// File: doc/BRIEF.md
# Masked Vector Load/Store Engine

This block moves one vector register image between the core and memory under a per-element enable mask. A single start pulse hands it a byte base address, an element width (32 or 64 bits), a vector width (128 or 256 bits), a load/store direction, the mask vector and, for stores, the data vector. The block then walks the elements from index 0 upward. For each enabled element it issues exactly one request on a simple memory port that carries one element per request. Disabled elements cause no memory traffic at all.

A load returns a full result vector. Enabled elements hold the data read from memory, and every other element is zero. A store writes only the enabled elements, so memory under disabled elements keeps its old contents. The base address does not have to be aligned to the vector size. Each element address is the base plus the element index times the element size in bytes. A mask with no enabled element finishes in the cycle after start and makes no access.

Top module: `vmx_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `mem_req` are 0 and `load_vec` is all zero.
- R2: An element is enabled only by the top bit of its own mask element. For 32-bit elements (`elem64`=0), element i uses `mask_vec[32*i+31]`. For 64-bit elements (`elem64`=1), element i uses `mask_vec[64*i+63]`. All other mask bits have no effect. With `wide`=1 the vector is 256 bits (8 or 4 elements). With `wide`=0 it is 128 bits (4 or 2 elements), and mask bits above that are ignored.
- R3: Requests come out in ascending element index. Each address is `base_addr + i*4` for 32-bit elements or `base_addr + i*8` for 64-bit elements, for any base alignment.
- R4: The number of memory requests equals the number of enabled elements, on both loads and stores.
- R5: On a load, enabled element i of `load_vec` takes the low 32 or 64 bits of `mem_rdata` returned for that element. Every disabled element, including every element beyond the vector width, reads as zero.
- R6: On a store, `mem_we`=1 and element i of `store_vec` is placed in the low bits of `mem_wdata`. `mem_be` is 8'h0F for 32-bit elements and 8'hFF for 64-bit elements. Bytes under disabled elements are never written.
- R7: A load request stays outstanding until `mem_rvalid`. No further request is issued while one is outstanding, and any response latency of one cycle or more is accepted.
- R8: With no enabled element, `done` is 1 in the cycle right after the start cycle. No request is issued, and a load leaves `load_vec` all zero.
- R9: `done` is a one-cycle pulse, high only when the block is idle. `busy` is high from the cycle after an accepted start until `done`. A `start` while busy is ignored.
- R10: A store never changes `load_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| is_store | input | 1 | 1 = store, 0 = load |
| elem64 | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| wide | input | 1 | 1 = 256-bit vector, 0 = 128-bit vector |
| base_addr | input | ADDR_W | Byte address of element 0, any alignment |
| mask_vec | input | VEC_W | Mask vector; the top bit of each element enables it |
| store_vec | input | VEC_W | Data vector for stores |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| load_vec | output | VEC_W | Load result, with disabled elements zeroed |
| mem_req | output | 1 | Memory request, one cycle per element |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the element |
| mem_wdata | output | 64 | Write data, with the element in the low bits |
| mem_be | output | 8 | Byte enables for the write |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read response data |

## Verification
Loads are tried with alternating, sparse, full and empty masks at both element widths and both vector widths. Comparing the request log with the zero-filled result separates a correct skip of disabled elements from reading them and then discarding the data. Masks whose non-top bits are all set on disabled elements, and whose top bits are set beyond a 128-bit vector, show whether only the intended bit decides enabling. Unaligned bases with memory latencies of one and three cycles test the address arithmetic and the wait for each response. Stores are checked byte by byte against a sparse memory model, including guard bytes on both sides, so that a write to a disabled element or a wrong byte enable becomes visible.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  localparam int SMALL_BITS = 32;
  localparam int LARGE_BITS = 64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } vmx_state_e;
endpackage

// File: rtl/vmx_lane_en.sv
module vmx_lane_en #(
  parameter int VEC_W = 256,
  parameter int N     = VEC_W / vmx_pkg::SMALL_BITS
) (
  input  logic [VEC_W-1:0] mask,
  input  logic             elem64,
  input  logic             wide,
  output logic [N-1:0]     en
);
  logic [N-1:0] m_small, m_large, lim_small, lim_large;

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign m_small[g] = mask[32*g+31];
    if (g < N/2) begin : g_lo
      assign m_large[g]   = mask[64*g+63];
      assign lim_small[g] = 1'b1;
    end else begin : g_hi
      assign m_large[g]   = 1'b0;
      assign lim_small[g] = wide;
    end
    if (g < N/4) begin : g_q
      assign lim_large[g] = 1'b1;
    end else if (g < N/2) begin : g_h
      assign lim_large[g] = wide;
    end else begin : g_n
      assign lim_large[g] = 1'b0;
    end
  end

  assign en = elem64 ? (m_large & lim_large) : (m_small & lim_small);
endmodule

// File: rtl/vmx_first_set.sv
module vmx_first_set #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/vmx_slot_mux.sv
module vmx_slot_mux #(
  parameter int VEC_W = 256,
  parameter int IDX_W = $clog2(VEC_W / vmx_pkg::SMALL_BITS)
) (
  input  logic [VEC_W-1:0] vec_in,
  input  logic [IDX_W-1:0] idx,
  input  logic             elem64,
  input  logic [63:0]      rdata,
  input  logic [VEC_W-1:0] cur_res,
  output logic [63:0]      slot_out,
  output logic [VEC_W-1:0] res_out
);
  localparam int OFF_W = $clog2(VEC_W);
  logic [OFF_W-1:0] off_s, off_l;

  assign off_s = {idx, 5'b0};
  assign off_l = {idx[IDX_W-2:0], 6'b0};

  always_comb begin
    slot_out = elem64 ? vec_in[off_l +: 64] : {32'b0, vec_in[off_s +: 32]};
    res_out  = cur_res;
    if (elem64) res_out[off_l +: 64] = rdata;
    else        res_out[off_s +: 32] = rdata[31:0];
  end
endmodule

// File: rtl/vmx_engine.sv
module vmx_engine #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_store,
  input  logic              elem64,
  input  logic              wide,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [VEC_W-1:0]  mask_vec,
  input  logic [VEC_W-1:0]  store_vec,
  output logic              busy,
  output logic              done,
  output logic [VEC_W-1:0]  load_vec,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_be,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);
  import vmx_pkg::*;

  localparam int N     = VEC_W / SMALL_BITS;
  localparam int IDX_W = $clog2(N);

  vmx_state_e        state;
  logic [N-1:0]      en_in, pend, pend_clr;
  logic              pend_any;
  logic [IDX_W-1:0]  nxt, cur_idx;
  logic [ADDR_W-1:0] base_q, lane_off;
  logic              e64_q, st_q;
  logic [VEC_W-1:0]  data_q, res_next;
  logic [63:0]       slot;
  logic [IDX_W-1:0]  mux_idx;

  vmx_lane_en #(.VEC_W(VEC_W), .N(N)) u_en (
    .mask(mask_vec), .elem64(elem64), .wide(wide), .en(en_in)
  );

  vmx_first_set #(.N(N), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .any(pend_any), .idx(nxt)
  );

  assign mux_idx = (state == ST_WAIT) ? cur_idx : nxt;

  vmx_slot_mux #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_mux (
    .vec_in(data_q), .idx(mux_idx), .elem64(e64_q), .rdata(mem_rdata),
    .cur_res(load_vec), .slot_out(slot), .res_out(res_next)
  );

  assign lane_off = e64_q ? (ADDR_W'(nxt) << 3) : (ADDR_W'(nxt) << 2);
  assign pend_clr = pend & ~(N'(1) << nxt);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= '0;
      cur_idx   <= '0;
      base_q    <= '0;
      e64_q     <= 1'b0;
      st_q      <= 1'b0;
      data_q    <= '0;
      load_vec  <= '0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pend   <= en_in;
            base_q <= base_addr;
            e64_q  <= elem64;
            st_q   <= is_store;
            data_q <= store_vec;
            if (!is_store) load_vec <= '0;
            if (en_in == '0) done  <= 1'b1;
            else             state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (pend_any) begin
            mem_req   <= 1'b1;
            mem_we    <= st_q;
            mem_addr  <= base_q + lane_off;
            mem_wdata <= slot;
            mem_be    <= e64_q ? 8'hFF : 8'h0F;
            cur_idx   <= nxt;
            pend      <= pend_clr;
            if (!st_q)               state <= ST_WAIT;
            else if (pend_clr == '0) state <= ST_FIN;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            load_vec <= res_next;
            if (pend == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vmx_engine_chk.sv
module vmx_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       mem_req,
  input logic       mem_we,
  input logic [7:0] mem_be,
  input logic       mem_rvalid
);
  logic rd_out;

  always_ff @(posedge clk) begin
    if (rst)                   rd_out <= 1'b0;
    else if (mem_req && !mem_we) rd_out <= 1'b1;
    else if (mem_rvalid)       rd_out <= 1'b0;
  end

  assert_read_waits_R7: assert property (@(posedge clk) disable iff (rst)
    rd_out |-> !mem_req);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));

  assert_req_in_op_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_store_be_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be == 8'h0F || mem_be == 8'hFF));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

bind vmx_engine vmx_engine_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_be(mem_be), .mem_rvalid(mem_rvalid)
);

// File: tb/vmx_engine_test.sv
module vmx_engine_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0, is_store = 1'b0, elem64 = 1'b0, wide = 1'b0;
  logic [31:0]  base_addr = '0;
  logic [255:0] mask_vec = '0, store_vec = '0;
  logic         busy, done, mem_req, mem_we;
  logic [255:0] load_vec;
  logic [31:0]  mem_addr;
  logic [63:0]  mem_wdata, mem_rdata;
  logic [7:0]   mem_be;
  logic         mem_rvalid;

  always #10 clk = ~clk;

  vmx_engine uut (
    .clk(clk), .rst(rst), .start(start), .is_store(is_store), .elem64(elem64),
    .wide(wide), .base_addr(base_addr), .mask_vec(mask_vec), .store_vec(store_vec),
    .busy(busy), .done(done), .load_vec(load_vec), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] mem [logic [31:0]];
  int         lat = 1, cnt = 0, viol = 0, req_n = 0;
  logic [31:0] pend_addr;
  logic [31:0] log_addr [16];
  logic        log_we [16];
  logic [7:0]  log_be [16];

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a[7:0] ^ a[15:8] ^ 8'h5A);
  endfunction

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  end

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = rd_byte(pend_addr + 32'(k));
      end
    end
    if (mem_req) begin
      if (req_n < 16) begin
        log_addr[req_n] = mem_addr;
        log_we[req_n]   = mem_we;
        log_be[req_n]   = mem_be;
      end
      req_n = req_n + 1;
      if (mem_we) begin
        for (int k = 0; k < 8; k++)
          if (mem_be[k]) mem[mem_addr + 32'(k)] = mem_wdata[8*k +: 8];
      end else begin
        if (cnt > 0) viol = viol + 1;
        cnt = lat;
        pend_addr = mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_mask(input bit e64, input logic [7:0] lanes);
    logic [255:0] m = '0;
    for (int i = 0; i < 8; i++) begin
      if (e64) begin
        if (i < 4) m[64*i +: 64] = lanes[i] ? {1'b1, 63'h0} : {1'b0, {63{1'b1}}};
      end else begin
        m[32*i +: 32] = lanes[i] ? {1'b1, 31'h0} : {1'b0, {31{1'b1}}};
      end
    end
    return m;
  endfunction

  task automatic run_op(input bit st, input bit e64, input bit wd, input logic [31:0] base,
                        input logic [7:0] lanes, input logic [255:0] data,
                        input int l, input bit poke, input string name);
    int n, sz, en_cnt, cyc, mism, j;
    logic [7:0]   snap [34];
    logic [255:0] exp_res, prior;
    bit           busy1;
    n  = (wd ? 8 : 4) >> (e64 ? 1 : 0);
    sz = e64 ? 8 : 4;
    en_cnt = 0;
    for (int i = 0; i < n; i++) if (lanes[i]) en_cnt++;
    for (int b = 0; b < 34; b++) snap[b] = rd_byte(base - 32'd1 + 32'(b));
    exp_res = '0;
    for (int i = 0; i < n; i++)
      if (lanes[i])
        for (int b = 0; b < sz; b++)
          exp_res[(i*sz+b)*8 +: 8] = rd_byte(base + 32'(i*sz + b));
    prior = load_vec;
    @(negedge clk);
    lat = l; req_n = 0; viol = 0;
    start = 1'b1; is_store = st; elem64 = e64; wide = wd; base_addr = base;
    mask_vec = mk_mask(e64, lanes); store_vec = data;
    @(negedge clk);
    start = 1'b0;
    busy1 = busy;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1; is_store = 1'b1; mask_vec = '1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(cyc < 200, "R9", {name, " watchdog"}, 256'(cyc), 256'(0));
    chk(busy1 == (en_cnt != 0), "R9", {name, " busy after start"}, 256'(busy1), 256'(en_cnt != 0));
    if (en_cnt == 0) chk(cyc == 1, "R8", {name, " empty mask done cycle"}, 256'(cyc), 256'(1));
    chk(req_n == en_cnt, "R4", {name, " request count"}, 256'(req_n), 256'(en_cnt));
    chk(viol == 0, "R7", {name, " overlapping read"}, 256'(viol), 256'(0));
    mism = 0; j = 0;
    for (int i = 0; i < n; i++)
      if (lanes[i] && j < 16) begin
        if (log_addr[j] !== base + 32'(i*sz) || log_we[j] !== st) mism++;
        j++;
      end
    chk(mism == 0, "R3", {name, " address order"}, 256'(mism), 256'(0));
    if (st) begin
      mism = 0;
      for (int k = 0; k < req_n && k < 16; k++) if (log_be[k] !== (e64 ? 8'hFF : 8'h0F)) mism++;
      for (int b = 0; b < 34; b++) begin
        logic [7:0] e;
        int off;
        off = b - 1;
        e = snap[b];
        if (off >= 0 && off < n*sz && lanes[off/sz]) e = data[(off)*8 +: 8];
        if (rd_byte(base - 32'd1 + 32'(b)) !== e) mism++;
      end
      chk(mism == 0, "R6", {name, " memory bytes"}, 256'(mism), 256'(0));
      chk(load_vec === prior, "R10", {name, " result untouched"}, load_vec, prior);
    end else begin
      chk(load_vec === exp_res, "R5", {name, " load result"}, load_vec, exp_res);
    end
    @(negedge clk);
    chk(!done, "R9", {name, " done single pulse"}, 256'(done), 256'(0));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_req, "R1", "reset outputs", {busy, done, mem_req}, 256'(0));
    chk(load_vec == '0, "R1", "reset result", load_vec, '0);
  endtask

  task automatic t_loads();
    run_op(0, 0, 1, 32'h0000_1000, 8'b1010_0101, '0, 1, 0, "R5 load32 wide alternating");
    run_op(0, 1, 0, 32'h0000_2003, 8'b1111_1110, '0, 3, 0, "R3 load64 narrow unaligned");
    run_op(0, 0, 0, 32'h0000_3001, 8'b1111_1111, '0, 2, 0, "R2 load32 narrow upper ignored");
    run_op(0, 1, 1, 32'h0000_4005, 8'b0000_1111, '0, 1, 0, "R5 load64 wide full");
  endtask

  task automatic t_stores();
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[32*i +: 32] = 32'hC0DE_0000 + 32'(i * 32'h1111);
    run_op(1, 0, 1, 32'h0000_5002, 8'b0100_1001, d, 1, 0, "R6 store32 wide sparse");
    run_op(1, 1, 1, 32'h0000_6007, 8'b0000_0110, d, 1, 0, "R6 store64 wide unaligned");
    run_op(1, 0, 0, 32'h0000_7000, 8'b1111_0011, d, 1, 0, "R2 store32 narrow upper ignored");
  endtask

  task automatic t_empty();
    run_op(0, 0, 1, 32'h0000_8000, 8'b0000_0000, '0, 1, 0, "R8 empty load");
    run_op(1, 1, 0, 32'h0000_8100, 8'b1111_1100, '1, 1, 0, "R8 empty store beyond width");
  endtask

  task automatic t_busy_start();
    run_op(0, 0, 1, 32'h0000_9001, 8'b0001_0110, '0, 3, 1, "R9 start while busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_loads();
    t_stores();
    t_empty();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R9 global watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule